// File: doc/BRIEF.md
# Conditional Branch Resolver

This combinational unit decides the outcome of a conditional branch in the execute stage of a 64-bit RISC-V core. It takes the program counter of the current instruction, the 32-bit instruction word and the two source register values. In the same cycle it returns whether the branch is taken, the branch target, and the address to fetch next.

Inside the unit, a control decoder reads the opcode and funct3 fields and turns them into one-hot compare strobes. A datapath takes those strobes, rebuilds the split immediate, adds it to the PC and runs the selected comparison. The datapath then picks between the target and the sequential address. Any instruction that is not a conditional branch is reported as not taken and falls through to the sequential address.

Top module: `branch_resolve`

## Requirements
- R1: `branchTarget` equals `pcIn` plus the immediate, taken modulo 2^64. The immediate is sign-extended from 13 bits: imm[12]=instr[31], imm[11]=instr[7], imm[10:5]=instr[30:25], imm[4:1]=instr[11:8], imm[0]=0.
- R2: With opcode instr[6:0]=1100011 and funct3 instr[14:12]=000, `takeBranch` is 1 exactly when `srcA` equals `srcB`.
- R3: With the branch opcode and funct3=001, `takeBranch` is 1 exactly when `srcA` differs from `srcB`.
- R4: With the branch opcode and funct3=100, `takeBranch` is 1 exactly when `srcA` is less than `srcB`, both read as signed two's-complement numbers.
- R5: With the branch opcode and funct3=101, `takeBranch` is 1 exactly when `srcA` is greater than or equal to `srcB`, both read as signed numbers.
- R6: `nextPc` equals `branchTarget` when `takeBranch` is 1, and equals `pcIn`+4 (modulo 2^64) otherwise.
- R7: When instr[6:0] is not 1100011, `takeBranch` is 0 and `nextPc` is `pcIn`+4, whatever the operands are.
- R8: With the branch opcode and funct3 equal to 010, 011, 110 or 111, `takeBranch` is 0 and `nextPc` is `pcIn`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pcIn | input | 64 | Address of the instruction being resolved |
| instrWord | input | 32 | Instruction word |
| srcA | input | 64 | First source register value |
| srcB | input | 64 | Second source register value |
| takeBranch | output | 1 | Branch is taken |
| branchTarget | output | 64 | PC plus the sign-extended branch offset |
| nextPc | output | 64 | Address to fetch next |

## Verification
The unit is combinational, so any internal error appears at the ports as soon as the inputs settle, in the same cycle.

- A mis-wired immediate bit moves `branchTarget` by a power of two. Negative offsets expose a missing sign extension.
- A wrong strobe decode flips `takeBranch` for one funct3 code. An unsigned compare in place of a signed one flips the outcome only when the operand signs differ, so the mixed-sign cases catch it.
- A swapped select in the next-PC mux shows up in `nextPc` on every taken or not-taken case.

// File: rtl/branch_pkg.sv
package branch_pkg;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [F3_W-1:0]  F3_EQ = 3'b000;
  localparam logic [F3_W-1:0]  F3_NE = 3'b001;
  localparam logic [F3_W-1:0]  F3_LT = 3'b100;
  localparam logic [F3_W-1:0]  F3_GE = 3'b101;

  typedef struct packed {
    logic isBranch;
    logic selEq;
    logic selNe;
    logic selLt;
    logic selGe;
  } cmpStrobeT;
endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instrWord,
  output cmpStrobeT       strobes
);
  localparam int F3_LO = 12;

  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;

  assign opcode = instrWord[OPC_W-1:0];
  assign funct3 = instrWord[F3_LO+F3_W-1:F3_LO];

  always_comb begin
    strobes = '0;
    strobes.isBranch = (opcode == OPC_BRANCH);
    if (strobes.isBranch) begin
      unique case (funct3)
        F3_EQ:   strobes.selEq = 1'b1;
        F3_NE:   strobes.selNe = 1'b1;
        F3_LT:   strobes.selLt = 1'b1;
        F3_GE:   strobes.selGe = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0({strobes.selEq, strobes.selNe, strobes.selLt, strobes.selGe})); // R8
    AST_NONBRANCH_QUIET: assert (strobes.isBranch || !(strobes.selEq | strobes.selNe | strobes.selLt | strobes.selGe)); // R7
  end
endmodule

// File: rtl/branch_datapath.sv
module branch_datapath
  import branch_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic [XLEN-1:0] pcIn,
  input  logic [ILEN-1:0] instrWord,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  cmpStrobeT       strobes,
  output logic            takeBranch,
  output logic [XLEN-1:0] branchTarget,
  output logic [XLEN-1:0] nextPc
);
  localparam int IMM_W  = 13;
  localparam int EXT_W  = XLEN - IMM_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [IMM_W-1:0] immRaw;
  logic [XLEN-1:0]  immExt;
  logic [XLEN-1:0]  seqPc;
  logic             isEq;
  logic             isLt;

  assign immRaw = {instrWord[31], instrWord[7], instrWord[30:25], instrWord[11:8], 1'b0};
  assign immExt = {{EXT_W{immRaw[IMM_W-1]}}, immRaw};

  assign branchTarget = pcIn + immExt;
  assign seqPc        = pcIn + STEP;

  assign isEq = (srcA == srcB);
  assign isLt = ($signed(srcA) < $signed(srcB));

  assign takeBranch = (strobes.selEq &  isEq) |
                      (strobes.selNe & ~isEq) |
                      (strobes.selLt &  isLt) |
                      (strobes.selGe & ~isLt);

  assign nextPc = takeBranch ? branchTarget : seqPc;

  always_comb begin
    AST_TARGET_ALIGNED: assert ((branchTarget[0] == pcIn[0])); // R1
    AST_EQ_TAKEN: assert (!(strobes.selEq && takeBranch) || (srcA == srcB)); // R2
    AST_NE_TAKEN: assert (!(strobes.selNe && takeBranch) || (srcA != srcB)); // R3
    AST_LT_SIGNED: assert (!(strobes.selLt && takeBranch) || ($signed(srcA) < $signed(srcB))); // R4
    AST_GE_SIGNED: assert (!(strobes.selGe && takeBranch) || ($signed(srcA) >= $signed(srcB))); // R5
    AST_FALLTHROUGH: assert (takeBranch || (nextPc - pcIn == STEP)); // R6
    AST_NONBRANCH_IDLE: assert (strobes.isBranch || !takeBranch); // R7
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import branch_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32
) (
  input  logic [XLEN-1:0] pcIn,
  input  logic [ILEN-1:0] instrWord,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            takeBranch,
  output logic [XLEN-1:0] branchTarget,
  output logic [XLEN-1:0] nextPc
);
  cmpStrobeT strobes;

  branch_ctrl #(.ILEN(ILEN)) u_ctrl (
    .instrWord(instrWord),
    .strobes  (strobes)
  );

  branch_datapath #(.XLEN(XLEN), .ILEN(ILEN)) u_dp (
    .pcIn        (pcIn),
    .instrWord   (instrWord),
    .srcA        (srcA),
    .srcB        (srcB),
    .strobes     (strobes),
    .takeBranch  (takeBranch),
    .branchTarget(branchTarget),
    .nextPc      (nextPc)
  );
endmodule

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pcIn = '0;
  logic [31:0] instrWord = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        takeBranch;
  logic [63:0] branchTarget;
  logic [63:0] nextPc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  branch_resolve dut (
    .pcIn(pcIn), .instrWord(instrWord), .srcA(srcA), .srcB(srcB),
    .takeBranch(takeBranch), .branchTarget(branchTarget), .nextPc(nextPc)
  );

  function automatic logic [31:0] encB(input logic [12:0] imm, input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd2, 5'd1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction

  function automatic logic expTake(input logic [2:0] f3, input logic [63:0] a, input logic [63:0] b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkOut(input string req, input logic eTake, input logic [63:0] eTgt,
                          input logic [63:0] eNext, input bit chkTgt);
    total++;
    if (takeBranch !== eTake || nextPc !== eNext || (chkTgt && branchTarget !== eTgt)) begin
      bad++;
      $display("FAIL %s: take=%0b tgt=%h next=%h expected take=%0b tgt=%h next=%h",
               req, takeBranch, branchTarget, nextPc, eTake, eTgt, eNext);
    end
  endtask

  task automatic runBranch(input string req, input logic [63:0] pc, input logic [12:0] imm,
                           input logic [2:0] f3, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] tgt;
    logic        tk;
    @(negedge clk);
    pcIn = pc; instrWord = encB(imm, f3); srcA = a; srcB = b;
    #2;
    tgt = pc + {{51{imm[12]}}, imm[12:1], 1'b0};
    tk  = expTake(f3, a, b);
    checkOut(req, tk, tgt, tk ? tgt : pc + 64'd4, 1'b1);
  endtask

  task automatic testEqual();
    runBranch("R2", 64'h1000, 13'd16, 3'b000, 64'd5, 64'd5);
    runBranch("R2", 64'h1000, 13'd16, 3'b000, 64'd5, 64'd6);
  endtask

  task automatic testNotEqual();
    runBranch("R3", 64'h2000, 13'h1FF8, 3'b001, 64'd9, 64'd3);
    runBranch("R3", 64'h2000, 13'h1FF8, 3'b001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic testLessThan();
    runBranch("R4", 64'h3000, 13'd256, 3'b100, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1);
    runBranch("R4", 64'h3000, 13'd256, 3'b100, 64'd1, 64'hFFFF_FFFF_FFFF_FFFE);
    runBranch("R4", 64'h3000, 13'd256, 3'b100, 64'd7, 64'd7);
  endtask

  task automatic testGreaterEqual();
    runBranch("R5", 64'h4000, 13'h1000, 3'b101, 64'd1, 64'h8000_0000_0000_0000);
    runBranch("R5", 64'h4000, 13'h1000, 3'b101, 64'h8000_0000_0000_0000, 64'd1);
    runBranch("R5", 64'h4000, 13'h1000, 3'b101, 64'd42, 64'd42);
  endtask

  task automatic testImmediate();
    runBranch("R1", 64'h10_0000, 13'h0FFE, 3'b000, 64'd0, 64'd0);
    runBranch("R1", 64'h10_0000, 13'h1002, 3'b000, 64'd0, 64'd0);
    runBranch("R1", 64'h10_0000, 13'h0800, 3'b000, 64'd0, 64'd0);
    runBranch("R1", 64'h10_0000, 13'h0AAA, 3'b000, 64'd0, 64'd0);
    runBranch("R1", 64'd4, 13'h1FF0, 3'b000, 64'd0, 64'd0);
  endtask

  task automatic testNextPc();
    runBranch("R6", 64'hFFFF_FFFF_FFFF_FFFC, 13'd8, 3'b001, 64'd1, 64'd1);
    runBranch("R6", 64'h5000, 13'h1FFC, 3'b001, 64'd1, 64'd2);
  endtask

  task automatic testNonBranch();
    @(negedge clk);
    pcIn = 64'h6000; instrWord = {encB(13'd32, 3'b000)} ^ 32'h0000_0004;
    srcA = 64'd3; srcB = 64'd3;
    #2;
    checkOut("R7", 1'b0, 64'd0, 64'h6004, 1'b0);
    @(negedge clk);
    instrWord = 32'h0000_006F;
    #2;
    checkOut("R7", 1'b0, 64'd0, 64'h6004, 1'b0);
  endtask

  task automatic testBadFunct3();
    for (int k = 0; k < 4; k++) begin
      logic [2:0] f3;
      f3 = (k == 0) ? 3'b010 : (k == 1) ? 3'b011 : (k == 2) ? 3'b110 : 3'b111;
      runBranch("R8", 64'h7000, 13'd64, f3, 64'd0, 64'd0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    pcIn = 64'h100; instrWord = 32'h0000_0013; srcA = '0; srcB = '0;
    #2;
    checkOut("R7", 1'b0, 64'd0, 64'h104, 1'b0);
    testEqual();
    testNotEqual();
    testLessThan();
    testGreaterEqual();
    testImmediate();
    testNextPc();
    testNonBranch();
    testBadFunct3();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule